// File: doc/BRIEF.md
# Skewed Divided Clock Output

This block makes one output clock from a fast reference tick. The tick stands in for an oscillator that runs at eight ticks per oscillator period, so a fine skew step is one tick and a coarse step is two ticks. The output period is the oscillator period times a programmable ratio taken from a 5-bit code. The output is high for exactly half of that period.

A 4-bit skew code delays every rising edge by 0 to 15 steps against an internal reference frame that starts when reset is released. A mode bit picks the fine or the coarse step size. When the delay is at least one period, it wraps modulo the period. New ratio, skew and mode values are sampled only at the start of an output period. A change therefore never produces a short pulse. When the skew shrinks, one period is stretched so that no period comes out short.

Two controls decide whether a period is shown on the pin. An enable is sampled at the start of each period and acts on that period. A run gate passes through a three-period pipeline before it acts. An output that is stopped stays low, and a pulse that has started always runs its full high phase.

Top module: `skew_divclk_out`

## Requirements
- R1: While reset is high, the output is low and both internal counters are cleared. After release, the first rising edge is seen on the 3P-th tick after the first tick whose edge counts as the first edge after release, counting d ticks more for the delay. With a tick count starting at 1 on the first edge after release, the first rise appears at tick d + 3P + 1 when gate and enable are both 1 throughout.
- R2: The output period P, in ticks, is (div_code + 1) * 8. A div_code of 0 gives 8 ticks.
- R3: Every output pulse is high for exactly P/2 ticks, for odd and even ratios alike.
- R4: With coarse_step = 0, the skew delay d is skew_code ticks, and code 0 adds no delay. When d >= P, rising edges fall at d mod P.
- R5: With coarse_step = 1, d is 2 * skew_code ticks, so code 15 gives 30 ticks.
- R6: The run_gate value sampled at the start of a period decides whether the period three starts later is shown (1 = shown, 0 = suppressed). After run_gate falls, exactly three more pulses appear.
- R7: A pulse that has started always completes its full high phase, even when enable or gate falls during it.
- R8: The out_enable value sampled at the start of a period decides that same period (1 = pulse, 0 = held low). No rising edge occurs without enable high at the period start.
- R9: div_code, skew_code and coarse_step are sampled only at the start of an output period. The pulse and period in progress keep their old length.
- R10: After a skew change, the next period is stretched to the next matching reference phase and is never shorter than P. Every low phase lasts at least the previous P/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference tick, 8 per oscillator period |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 5 | Ratio code; ratio is code + 1 |
| skew_code | input | 4 | Delay in steps, 0 to 15 |
| coarse_step | input | 1 | 0 = one tick per step, 1 = two ticks per step |
| out_enable | input | 1 | Output enable, sampled at each period start |
| run_gate | input | 1 | Run request, acts three periods later |
| clk_out | output | 1 | Divided, skewed output clock |

## Verification
Results are due at four different delays.

- **Period start:** a period start decided at a tick edge shows on the pin at that same edge. The bench samples on the falling half of the tick and records the edge times against a tick count that is 1 at the first edge after reset.
- **First edge after reset:** it is due at tick d + 3P + 1, and the checks compare that exact value.
- **Gate:** a gate change acts three period starts after it is first sampled. Because the first sample lands anywhere within one period, the start check accepts a window from 3P+1 to 4P ticks, and the stop check counts exactly three further pulses.
- **Ratio and skew changes:** these are made just after a rise is seen. The first period after the change keeps the old length, and the new value shows from the next period on; for skew changes that next period is the stretched one.

// File: rtl/skdc_pkg.sv
package skdc_pkg;
   typedef enum logic {
      STEP_FINE   = 1'b0,
      STEP_COARSE = 1'b1
   } step_mode_e;

   function automatic int unsigned ticks_per_step(input step_mode_e mode, input int unsigned tpv);
      return (mode == STEP_COARSE) ? tpv / 4 : tpv / 8;
   endfunction
endpackage

// File: rtl/skdc_cfg_latch.sv
module skdc_cfg_latch
   import skdc_pkg::*;
#(
   parameter int DIV_W = 5,
   parameter int SKEW_W = 4,
   parameter int TICKS_PER_VCO = 8,
   parameter int CNT_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DIV_W-1:0]  div_code,
   input  logic [SKEW_W-1:0] skew_code,
   input  logic              coarse_step,
   output logic [CNT_W-1:0]  per_lat,
   output logic [CNT_W-1:0]  half_lat,
   output logic [CNT_W-1:0]  dly_lat
);
   logic [CNT_W-1:0] per_new;
   logic [CNT_W-1:0] dly_new;
   step_mode_e       mode;

   assign mode    = step_mode_e'(coarse_step);
   assign per_new = CNT_W'((int'(div_code) + 1) * TICKS_PER_VCO);
   assign dly_new = CNT_W'(int'(skew_code) * int'(ticks_per_step(mode, TICKS_PER_VCO)));

   always_ff @(posedge clk) begin
      if (rst || load) begin
         per_lat  <= per_new;
         half_lat <= per_new >> 1;
         dly_lat  <= dly_new;
      end
   end
endmodule

// File: rtl/skdc_phase_track.sv
module skdc_phase_track #(
   parameter int CNT_W = 9,
   parameter int MOD_ITER = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] per_lat,
   input  logic [CNT_W-1:0] dly_lat,
   output logic             slot
);
   logic [CNT_W-1:0] ref_cnt;
   logic [CNT_W-1:0] since_cnt;
   logic [CNT_W-1:0] dly_mod;

   // delay reduced into one period; bounded number of subtract steps
   always_comb begin
      dly_mod = dly_lat;
      for (int i = 0; i < MOD_ITER; i++) begin
         if (dly_mod >= per_lat) dly_mod = dly_mod - per_lat;
      end
   end

   assign slot = (ref_cnt == dly_mod) && (since_cnt >= per_lat);

   // reference frame, wraps at the latched period
   always_ff @(posedge clk) begin
      if (rst) ref_cnt <= '0;
      else if (ref_cnt >= per_lat - CNT_W'(1)) ref_cnt <= '0;
      else ref_cnt <= ref_cnt + CNT_W'(1);
   end

   // ticks since the last period start, saturating; ready value after reset
   always_ff @(posedge clk) begin
      if (rst) since_cnt <= '1;
      else if (slot) since_cnt <= CNT_W'(1);
      else if (since_cnt != '1) since_cnt <= since_cnt + CNT_W'(1);
   end
endmodule

// File: rtl/skdc_gate_ctl.sv
module skdc_gate_ctl #(
   parameter int CNT_W = 9,
   parameter int GATE_LAT = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             slot,
   input  logic             out_enable,
   input  logic             run_gate,
   input  logic [CNT_W-1:0] half_lat,
   output logic             clk_out
);
   logic             gate_ok;
   logic             out_q;
   logic [CNT_W-1:0] hi_cnt;

   generate
      if (GATE_LAT == 0) begin : g_direct
         assign gate_ok = run_gate;
      end else begin : g_pipe
         logic [GATE_LAT-1:0] gq;
         for (genvar i = 0; i < GATE_LAT; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst) gq[i] <= 1'b0;
               else if (slot) gq[i] <= (i == 0) ? run_gate : gq[(i == 0) ? 0 : i-1];
            end
         end
         assign gate_ok = gq[GATE_LAT-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         out_q  <= 1'b0;
         hi_cnt <= '0;
      end else if (slot) begin
         out_q  <= out_enable && gate_ok;
         hi_cnt <= CNT_W'(1);
      end else if (out_q) begin
         if (hi_cnt >= half_lat) out_q <= 1'b0;
         hi_cnt <= hi_cnt + CNT_W'(1);
      end
   end

   assign clk_out = out_q;
endmodule

// File: rtl/skew_divclk_out.sv
module skew_divclk_out #(
   parameter int DIV_W = 5,
   parameter int SKEW_W = 4,
   parameter int TICKS_PER_VCO = 8,
   parameter int GATE_LAT = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIV_W-1:0]  div_code,
   input  logic [SKEW_W-1:0] skew_code,
   input  logic              coarse_step,
   input  logic              out_enable,
   input  logic              run_gate,
   output logic              clk_out
);
   localparam int MAX_PER  = (2 ** DIV_W) * TICKS_PER_VCO;
   localparam int CNT_W    = $clog2(MAX_PER) + 1;
   localparam int MAX_DLY  = ((2 ** SKEW_W) - 1) * TICKS_PER_VCO / 4;
   localparam int MOD_ITER = (MAX_DLY + TICKS_PER_VCO - 1) / TICKS_PER_VCO;

   generate
      if (TICKS_PER_VCO < 8 || (TICKS_PER_VCO % 8) != 0) begin : g_bad_tpv
         $error("TICKS_PER_VCO must be a positive multiple of 8");
      end
      if (MAX_DLY >= (2 ** CNT_W)) begin : g_bad_dly
         $error("skew range does not fit the counter width");
      end
      if (GATE_LAT < 0 || GATE_LAT > 8) begin : g_bad_lat
         $error("GATE_LAT must lie in 0..8");
      end
   endgenerate

   logic [CNT_W-1:0] per_lat;
   logic [CNT_W-1:0] half_lat;
   logic [CNT_W-1:0] dly_lat;
   logic             slot;

   skdc_cfg_latch #(
      .DIV_W(DIV_W), .SKEW_W(SKEW_W), .TICKS_PER_VCO(TICKS_PER_VCO), .CNT_W(CNT_W)
   ) u_cfg (
      .clk(clk), .rst(rst), .load(slot),
      .div_code(div_code), .skew_code(skew_code), .coarse_step(coarse_step),
      .per_lat(per_lat), .half_lat(half_lat), .dly_lat(dly_lat)
   );

   skdc_phase_track #(
      .CNT_W(CNT_W), .MOD_ITER(MOD_ITER)
   ) u_phase (
      .clk(clk), .rst(rst), .per_lat(per_lat), .dly_lat(dly_lat), .slot(slot)
   );

   skdc_gate_ctl #(
      .CNT_W(CNT_W), .GATE_LAT(GATE_LAT)
   ) u_gate (
      .clk(clk), .rst(rst), .slot(slot), .out_enable(out_enable),
      .run_gate(run_gate), .half_lat(half_lat), .clk_out(clk_out)
   );
endmodule

// File: rtl/skdc_chk.sv
module skdc_chk #(
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             clk_out,
   input logic             out_enable,
   input logic             slot,
   input logic [CNT_W-1:0] per_lat,
   input logic [CNT_W-1:0] half_lat
);
   logic [CNT_W-1:0] hi_run;
   logic [CNT_W-1:0] lo_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_run <= '0;
         lo_run <= '1;
      end else if (clk_out) begin
         hi_run <= hi_run + CNT_W'(1);
         lo_run <= '0;
      end else begin
         hi_run <= '0;
         if (lo_run != '1) lo_run <= lo_run + CNT_W'(1);
      end
   end

   // R1: output low on the first edge after reset
   a_r1_low_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !clk_out);

   // R3 and R7: each high phase lasts exactly the latched half period
   a_r3_high_len: assert property (@(posedge clk) disable iff (rst)
      $fell(clk_out) |-> hi_run == $past(half_lat));

   // R8: a rise needs enable at the period start
   a_r8_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
      $rose(clk_out) |-> $past(out_enable));

   // R9: the period setting moves only at a period start
   a_r9_cfg_at_start: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$stable(per_lat)) |-> $past(slot));

   // R10: no low phase shorter than the previous half period
   a_r10_low_min: assert property (@(posedge clk) disable iff (rst)
      $rose(clk_out) |-> lo_run >= $past(half_lat));
endmodule

bind skew_divclk_out skdc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .clk_out(clk_out), .out_enable(out_enable),
   .slot(slot), .per_lat(per_lat), .half_lat(half_lat)
);

// File: tb/sim_skew_divclk_out.sv
`timescale 1ns/1ps
module sim_skew_divclk_out;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] div_code = 5'd3;
   logic [3:0] skew_code = 4'd0;
   logic       coarse_step = 1'b0;
   logic       out_enable = 1'b1;
   logic       run_gate = 1'b1;
   logic       clk_out;

   int checks = 0;
   int fails = 0;
   int t = 0;
   int cyc = 0;
   int rise_cnt = 0;
   int last_rise = 0;
   int prev_rise = 0;
   int last_high = 0;
   logic prev_out = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   skew_divclk_out u0 (
      .clk(clk), .rst(rst), .div_code(div_code), .skew_code(skew_code),
      .coarse_step(coarse_step), .out_enable(out_enable), .run_gate(run_gate),
      .clk_out(clk_out)
   );

   always @(posedge clk) begin
      if (rst) t <= 0;
      else t <= t + 1;
   end

   always @(negedge clk) begin
      if (clk_out && !prev_out) begin
         prev_rise = last_rise;
         last_rise = t;
         rise_cnt  = rise_cnt + 1;
      end
      if (!clk_out && prev_out) last_high = t - last_rise;
      prev_out = clk_out;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_rise();
      int start = rise_cnt;
      int n = 0;
      while (rise_cnt == start && n < 3000) begin
         tick();
         n++;
      end
   endtask

   task automatic wait_fall();
      int n = 0;
      while (clk_out && n < 3000) begin
         tick();
         n++;
      end
   endtask

   task automatic count_rises(input int cycles, output int got);
      int start = rise_cnt;
      repeat (cycles) tick();
      got = rise_cnt - start;
   endtask

   task automatic apply_reset(input int dv, input int sk, input bit crs);
      tick();
      rst = 1'b1;
      div_code = 5'(dv);
      skew_code = 4'(sk);
      coarse_step = crs;
      out_enable = 1'b1;
      run_gate = 1'b1;
      repeat (3) tick();
      rst = 1'b0;
   endtask

   task automatic t_reset_start();
      apply_reset(3, 0, 1'b0);
      rst = 1'b1;
      tick();
      check(clk_out == 1'b0, "R1 low in reset", int'(clk_out), 0);
      rst = 1'b0;
      wait_rise();
      check(last_rise == 97, "R1 first rise tick", last_rise, 97);
      wait_rise();
      check(last_rise - prev_rise == 32, "R2 period div3", last_rise - prev_rise, 32);
      wait_fall();
      check(last_high == 16, "R3 high div3", last_high, 16);
   endtask

   task automatic t_divide(input int dv);
      int p = (dv + 1) * 8;
      apply_reset(dv, 0, 1'b0);
      repeat (4) wait_rise();
      check(last_rise - prev_rise == p, "R2 period", last_rise - prev_rise, p);
      wait_fall();
      check(last_high == p / 2, "R3 half period", last_high, p / 2);
   endtask

   task automatic t_first_rise(input int dv, input int sk, input bit crs, input int exp, input string tag);
      apply_reset(dv, sk, crs);
      wait_rise();
      check(last_rise == exp, tag, last_rise, exp);
   endtask

   task automatic t_gate();
      int got;
      int tg;
      apply_reset(1, 0, 1'b0);
      repeat (2) wait_rise();
      run_gate = 1'b0;
      count_rises(160, got);
      check(got == 3, "R6 pulses after gate stop", got, 3);
      check(last_high == 8, "R7 last pulse full", last_high, 8);
      tg = t;
      run_gate = 1'b1;
      wait_rise();
      check(last_rise - tg >= 49 && last_rise - tg <= 64, "R6 restart delay", last_rise - tg, 56);
   endtask

   task automatic t_enable();
      int got;
      int te;
      apply_reset(1, 0, 1'b0);
      repeat (2) wait_rise();
      out_enable = 1'b0;
      wait_fall();
      check(last_high == 8, "R7 pulse completes after enable drop", last_high, 8);
      count_rises(64, got);
      check(got == 0, "R8 held low while disabled", got, 0);
      te = t;
      out_enable = 1'b1;
      wait_rise();
      check(last_rise - te >= 1 && last_rise - te <= 16, "R8 resume within one period", last_rise - te, 8);
   endtask

   task automatic t_div_change();
      apply_reset(1, 0, 1'b0);
      repeat (2) wait_rise();
      div_code = 5'd3;
      wait_fall();
      check(last_high == 8, "R9 current pulse keeps old length", last_high, 8);
      wait_rise();
      check(last_rise - prev_rise == 16, "R9 current period keeps old length", last_rise - prev_rise, 16);
      wait_fall();
      check(last_high == 16, "R9 new high phase", last_high, 16);
      wait_rise();
      check(last_rise - prev_rise == 32, "R9 new period", last_rise - prev_rise, 32);
   endtask

   task automatic t_skew_change();
      apply_reset(1, 0, 1'b0);
      repeat (2) wait_rise();
      skew_code = 4'd4;
      wait_rise();
      check(last_rise - prev_rise == 16, "R10 period at skew latch", last_rise - prev_rise, 16);
      wait_rise();
      check(last_rise - prev_rise == 20, "R10 stretched by skew increase", last_rise - prev_rise, 20);
      wait_rise();
      check(last_rise - prev_rise == 16, "R10 steady after increase", last_rise - prev_rise, 16);
      skew_code = 4'd1;
      wait_rise();
      wait_rise();
      check(last_rise - prev_rise == 29, "R10 stretched on skew decrease", last_rise - prev_rise, 29);
      wait_fall();
      check(last_high == 8, "R10 pulse after stretch", last_high, 8);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      t_reset_start();
      t_divide(0);
      t_divide(4);
      t_divide(31);
      t_first_rise(3, 5, 1'b0, 102, "R4 fine skew 5");
      t_first_rise(3, 15, 1'b0, 112, "R4 fine skew 15");
      t_first_rise(0, 13, 1'b0, 30, "R4 skew wraps in period");
      t_first_rise(3, 15, 1'b1, 127, "R5 coarse skew 15");
      t_first_rise(3, 3, 1'b1, 103, "R5 coarse skew 3");
      t_gate();
      t_enable();
      t_div_change();
      t_skew_change();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule